// File: doc/BRIEF.md
# Complementary Dead-Time Drive Generator

The block turns one PWM level into a pair of non-overlapping drive signals for a half bridge. The "same" output is active while the PWM input is high. The "inverse" output is active while the PWM input is low. Whenever the input changes level, the output that is losing its active state is released at once. The output that is gaining its active state is held back for a programmed dead time, so the two switches of a leg are never driven together.

The dead time is a 16-bit count of prescaled clock periods. The prescaler divides the block clock by a power of two chosen by a 3-bit code. A 3-bit mode code enables the generator: only code 3'b100 runs it, and every other code parks both outputs inactive. A polarity bit chooses between active-high and active-low drive. When the PWM source stops toggling, no edges arrive and the outputs hold their levels.

Top module: `dtg_complementary`

## Requirements
- R1: While `rst` is high, both outputs are registered to the inactive level. The inactive level equals `polarity`.
- R2: Only `mode_sel` = 3'b100 enables the generator. Any other code drives both outputs inactive from the next clock and cancels a pending turn-on. Re-entering 3'b100 then behaves as described in R11.
- R3: In steady state, with the active level taken as 1, `drv_same` equals the PWM input and `drv_inv` equals its inverse.
- R4: The clock edge that first samples a new PWM level is the edge at which the output that is turning off goes inactive. That output is visible one cycle after the input change.
- R5: For a nonzero `dead_count` N and `presc_sel` code S (0 to 6, divide by 2^S, so code 3'b001 divides by 2), the output that is turning on goes active exactly N·2^S clocks after the edge of R4. N and S are captured or used as set at that edge; S must stay stable during the wait.
- R6: When `dead_count` is 0, both outputs switch at the same edge as direct complements of the input, with no gap.
- R7: If the input returns before the dead time ends, the pending turn-on is cancelled. A fresh full dead time is then counted from the new edge.
- R8: The two outputs are never active in the same cycle.
- R9: When `polarity` is 1, both outputs are active-low. The active patterns of R3 to R7 appear inverted at the pins.
- R10: With a constant PWM input and no pending turn-on, the outputs do not change.
- R11: The first enabled cycle after reset or after a disabled period counts as an input edge. The output matching the current input level turns on only after the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM level to be split into two drives |
| mode_sel | input | 3 | Waveform mode code; 3'b100 = dead-time mode |
| polarity | input | 1 | 0 = active-high outputs, 1 = active-low outputs |
| presc_sel | input | 3 | Prescaler code S, dead-time tick every 2^S clocks |
| dead_count | input | 16 | Dead time in prescaled ticks |
| drv_same | output | 1 | Drive following the PWM level, delayed on turn-on |
| drv_inv | output | 1 | Drive following the inverted level, delayed on turn-on |

## Verification
The two functions that can fall in the same cycle are the expiry of a running dead-time count and a new input edge. The same applies to a mode change arriving while a count runs. The bench provokes both cases: it toggles the input back inside the dead window, and it toggles every cycle with a one-tick dead time. It also drops the mode code mid-wait. A behavioural reference model, which counts the wait as a plain integer of clocks, is compared with both pins on every clock. In each collision the new edge or the disable must win, and no output may be asserted.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int DTG_NUM_OUTS = 2;
  localparam int DTG_OUT_SAME = 0;
  localparam int DTG_OUT_INV  = 1;
  localparam logic [2:0] DTG_MODE_DEADTIME = 3'b100;

  // Terminal count of the prescaler for a divide-by-2^sel, clamped to the max.
  function automatic int unsigned dtg_div_limit(input int unsigned sel, input int unsigned max_log2);
    int unsigned s;
    s = (sel > max_log2) ? max_log2 : sel;
    return (32'd1 << s) - 32'd1;
  endfunction
endpackage

// File: rtl/dtg_edge_track.sv
module dtg_edge_track (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pwm_in,
  output logic edge_det,
  output logic level
);
  logic pwm_q;
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      pwm_q <= pwm_in;
      en_q  <= en;
    end
  end

  // A fresh enable is treated like an edge so turn-on always waits.
  assign edge_det = en & ((pwm_in != pwm_q) | ~en_q);
  assign level    = pwm_q;
endmodule

// File: rtl/dtg_prescaler.sv
module dtg_prescaler #(
  parameter int SEL_W    = 3,
  parameter int MAX_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = CNT_W'(dtg_pkg::dtg_div_limit(32'(sel), MAX_LOG2));
  end

  assign tick = run & (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dtg_dead_counter.sv
module dtg_dead_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             pending,
  output logic             expire
);
  logic [CNT_W-1:0] remain;

  assign expire = pending & tick & (remain == CNT_W'(1)) & ~load & ~clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pending <= 1'b0;
      remain  <= '0;
    end else if (load) begin
      pending <= 1'b1;
      remain  <= load_val;
    end else if (pending && tick) begin
      remain <= remain - 1'b1;
      if (remain == CNT_W'(1)) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dtg_complementary.sv
module dtg_complementary #(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 3,
  parameter int MAX_LOG2 = 6,
  parameter int MODE_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwm_in,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              polarity,
  input  logic [SEL_W-1:0]  presc_sel,
  input  logic [CNT_W-1:0]  dead_count,
  output logic              drv_same,
  output logic              drv_inv
);
  localparam int NOUT = dtg_pkg::DTG_NUM_OUTS;
  localparam logic [MODE_W-1:0] MODE_RUN = MODE_W'(dtg_pkg::DTG_MODE_DEADTIME);

  logic            en;
  logic            edge_det;
  logic            level;
  logic            tick;
  logic            pending;
  logic            expire;
  logic            dt_zero;
  logic [NOUT-1:0] act_q;
  logic [NOUT-1:0] act_n;
  logic [NOUT-1:0] out_q;

  assign en      = (mode_sel == MODE_RUN);
  assign dt_zero = (dead_count == '0);

  dtg_edge_track u_edge (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .pwm_in   (pwm_in),
    .edge_det (edge_det),
    .level    (level)
  );

  dtg_prescaler #(
    .SEL_W    (SEL_W),
    .MAX_LOG2 (MAX_LOG2)
  ) u_presc (
    .clk  (clk),
    .rst  (rst),
    .clr  (edge_det | ~en),
    .run  (pending),
    .sel  (presc_sel),
    .tick (tick)
  );

  dtg_dead_counter #(
    .CNT_W (CNT_W)
  ) u_dead (
    .clk      (clk),
    .rst      (rst),
    .clear    (~en),
    .load     (edge_det & ~dt_zero),
    .load_val (dead_count),
    .tick     (tick),
    .pending  (pending),
    .expire   (expire)
  );

  // Next active state, before polarity.
  always_comb begin
    act_n = act_q;
    if (!en) begin
      act_n = '0;
    end else if (edge_det) begin
      act_n = '0;
      if (dt_zero) begin
        act_n[dtg_pkg::DTG_OUT_SAME] = pwm_in;
        act_n[dtg_pkg::DTG_OUT_INV]  = ~pwm_in;
      end
    end else if (expire) begin
      act_n[dtg_pkg::DTG_OUT_SAME] = level;
      act_n[dtg_pkg::DTG_OUT_INV]  = ~level;
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[i] <= 1'b0;
        out_q[i] <= polarity;
      end else begin
        act_q[i] <= act_n[i];
        out_q[i] <= act_n[i] ^ polarity;
      end
    end
  end

  assign drv_same = out_q[dtg_pkg::DTG_OUT_SAME];
  assign drv_inv  = out_q[dtg_pkg::DTG_OUT_INV];
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int CNT_W  = 16,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              pwm_in,
  input logic [MODE_W-1:0] mode_sel,
  input logic [CNT_W-1:0]  dead_count,
  input logic              act_same,
  input logic              act_inv
);
  logic en;
  assign en = (mode_sel == MODE_W'(dtg_pkg::DTG_MODE_DEADTIME));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    !(act_same && act_inv));

  assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!act_same && !act_inv));

  assert_off_at_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (pwm_in != $past(pwm_in)) && (dead_count != '0))
      |=> (!act_same && !act_inv));

  assert_zero_dead_R6: assert property (@(posedge clk) disable iff (rst)
    (en && (dead_count == '0) && ((pwm_in != $past(pwm_in)) || !$past(en)))
      |=> ((act_same == $past(pwm_in)) && (act_inv == !$past(pwm_in))));
endmodule

bind dtg_complementary dtg_checker #(
  .CNT_W  (CNT_W),
  .MODE_W (MODE_W)
) u_dtg_checker (
  .clk        (clk),
  .rst        (rst),
  .pwm_in     (pwm_in),
  .mode_sel   (mode_sel),
  .dead_count (dead_count),
  .act_same   (act_q[0]),
  .act_inv    (act_q[1])
);

// File: tb/tb_dtg_complementary.sv
module tb_dtg_complementary;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwm_in = 1'b0;
  logic [2:0]  mode_sel = 3'b100;
  logic        polarity = 1'b0;
  logic [2:0]  presc_sel = 3'd0;
  logic [15:0] dead_count = 16'd3;
  logic        drv_same;
  logic        drv_inv;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  bit m_lvl = 0, m_en = 0, m_pend = 0, m_a_same = 0, m_a_inv = 0;
  bit e_same = 0, e_inv = 0;
  int m_wait = 0;

  dtg_complementary dut (
    .clk        (clk),
    .rst        (rst),
    .pwm_in     (pwm_in),
    .mode_sel   (mode_sel),
    .polarity   (polarity),
    .presc_sel  (presc_sel),
    .dead_count (dead_count),
    .drv_same   (drv_same),
    .drv_inv    (drv_inv)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    bit en, edge_seen;
    if (rst) begin
      m_lvl = 0; m_en = 0; m_pend = 0; m_wait = 0;
      m_a_same = 0; m_a_inv = 0;
      e_same = polarity; e_inv = polarity;
    end else begin
      en = (mode_sel == 3'b100);
      edge_seen = en && ((pwm_in != m_lvl) || !m_en);
      if (!en) begin
        m_a_same = 0; m_a_inv = 0; m_pend = 0;
      end else if (edge_seen) begin
        if (dead_count == 0) begin
          m_a_same = pwm_in; m_a_inv = !pwm_in; m_pend = 0;
        end else begin
          m_a_same = 0; m_a_inv = 0; m_pend = 1;
          m_wait = int'(dead_count) * (1 << presc_sel);
        end
      end else if (m_pend) begin
        m_wait = m_wait - 1;
        if (m_wait == 0) begin
          m_a_same = m_lvl; m_a_inv = !m_lvl; m_pend = 0;
        end
      end
      m_lvl = pwm_in;
      m_en = en;
      e_same = m_a_same ^ polarity;
      e_inv = m_a_inv ^ polarity;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      compared++;
      if (drv_same !== e_same || drv_inv !== e_inv) begin
        mismatched++;
        $display("FAIL %s: got same=%b inv=%b expected same=%b inv=%b at cycle %0d",
                 cur_req, drv_same, drv_inv, e_same, e_inv, cycles);
      end
      // R8: independent overlap check at the pins
      compared++;
      if ((drv_same ^ polarity) && (drv_inv ^ polarity) && !rst) begin
        mismatched++;
        $display("FAIL R8: got both active same=%b inv=%b expected at most one", drv_same, drv_inv);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: got no end expected end before 100000 cycles");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flip(input int n);
    pwm_in = ~pwm_in;
    idle(n);
  endtask

  initial begin
    cur_req = "R1";
    idle(4);
    rst = 1'b0;
    cur_req = "R11";
    idle(10);
    cur_req = "R4";                      // also R3, R5 with S=0 N=3
    flip(10); flip(10);
    cur_req = "R5";                      // S=1 divides by 2: N=16 -> 32 clocks
    presc_sel = 3'd1; dead_count = 16'h0010;
    flip(50); flip(50);
    presc_sel = 3'd2; dead_count = 16'd5;
    flip(30); flip(30);
    cur_req = "R7";
    presc_sel = 3'd0; dead_count = 16'd10;
    flip(4); flip(4); flip(20);
    dead_count = 16'd1;
    for (int k = 0; k < 12; k++) flip(1);
    idle(6);
    cur_req = "R6";
    dead_count = 16'd0;
    for (int k = 0; k < 6; k++) flip(3);
    cur_req = "R9";
    polarity = 1'b1; dead_count = 16'd2;
    flip(8); flip(8);
    polarity = 1'b0;
    idle(4);
    cur_req = "R2";
    dead_count = 16'd20;
    flip(5);
    mode_sel = 3'b011;
    idle(10);
    cur_req = "R11";
    mode_sel = 3'b100;
    idle(30);
    cur_req = "R10";
    idle(40);
    cur_req = "R3";
    dead_count = 16'd2;
    flip(6); flip(6);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule